// File: doc/BRIEF.md
# Real-Time Clock Interrupt Flags and Alarm Comparator

This block is the interrupt section of a real-time clock. It takes three event inputs from the rest of the clock: a periodic-rate tick, a strobe that marks the end of each once-per-second time update, and the current seconds, minutes and hours bytes. It holds three alarm bytes and a control register. From these it keeps a periodic flag, an alarm flag and an update-done flag, and drives an active-low interrupt request.

Each flag is set by its own event whatever its enable bit holds. The enable bits only decide which flags may pull the interrupt line low. The alarm is tested once per update strobe. Each of the three alarm bytes either has to equal its time field or acts as a wildcard. A host uses a plain register port with one-cycle write and read strobes. A read of the status register returns the flags and clears them. That read is how the host acknowledges the interrupt.

The register port is control traffic and not a data stream, so it has no valid/ready handshake. A write takes effect at the clock edge where `wr_en` is high. Read data is combinational while `rd_en` is high. Any read side effect happens at that same edge.

Top module: `rtc_irq_unit`

## Requirements
- R1: A periodic tick sets the periodic flag on the next clock edge, even when the periodic enable is 0.
- R2: An update strobe sets the update-done flag on the next clock edge, even when the update enable is 0.
- R3: On an update strobe the alarm flag is set when the seconds, minutes and hours inputs each match their alarm bytes. The alarm bytes are at address 0 (seconds), 1 (minutes) and 2 (hours). A mismatch in any field leaves the alarm flag clear.
- R4: An alarm byte whose bits [7:6] are 2'b11 matches every value of its field. The patterns 2'b10 and 2'b01 in those bits get no wildcard treatment.
- R5: `irq_n` is 0 exactly when at least one flag is set and its own enable is also set. While the alarm enable is 0, the alarm flag alone never drives `irq_n` low.
- R6: A control write that moves the set-inhibit bit from 0 to 1 clears the update enable, whatever is written to that bit. A write while set-inhibit is already 1 stores the update enable as written.
- R7: Reset clears the control register, the alarm bytes and all flags, and sets `irq_n` to 1. The periodic and alarm enables change only on host writes.
- R8: Control at address 3 holds bit 7 set-inhibit, bit 6 periodic enable, bit 5 alarm enable and bit 4 update enable. Bits 3:0 read as 0. Status at address 4 reads bit 7 as the inverse of `irq_n`, bit 6 periodic flag, bit 5 alarm flag and bit 4 update-done flag. Its other bits read as 0.
- R9: A status read clears all flags at that edge. A flag event in the same cycle as the read wins, so the flag is set afterwards.
- R10: The alarm flag is set only in the cycle after an update strobe. A matching time with no strobe does not set it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Periodic-rate tick, one cycle wide |
| upd_i | input | 1 | End-of-update strobe, one cycle wide |
| sec_i | input | DW | Current seconds byte |
| min_i | input | DW | Current minutes byte |
| hour_i | input | DW | Current hours byte |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Register address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data (0 when `rd_en` is low) |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with its defaults: 8-bit bytes, a 3-bit address and three alarm fields. That keeps every enable and flag combination small enough to cover in full. It sweeps all eight enable patterns against every reachable flag pattern and checks both `irq_n` and the status byte against values computed from bitwise ANDs. It sweeps the seconds input over all 64 six-bit values against a fixed alarm, and it walks all eight wildcard masks with both matching and mismatching times. Directed cases cover the set-inhibit edge, a read that collides with a tick, and a held match with no strobe.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

  // Flag/enable triple; member order matches status and control bits 6..4
  typedef struct packed {
    logic pf;  // periodic
    logic af;  // alarm
    logic uf;  // update done
  } irq_vec_t;

  localparam int unsigned BIT_TOP   = 7;
  localparam int unsigned BIT_PF    = 6;
  localparam int unsigned BIT_AF    = 5;
  localparam int unsigned BIT_UF    = 4;
  localparam int unsigned ADDR_CTL  = 3;
  localparam int unsigned ADDR_STAT = 4;

endpackage

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int unsigned DW = 8,
  parameter int unsigned NF = 3
) (
  input  logic [NF-1:0][DW-1:0] now_t,
  input  logic [NF-1:0][DW-1:0] alm,
  output logic                  hit
);
  logic [NF-1:0] field_ok;

  for (genvar f = 0; f < NF; f++) begin : g_field
    logic wild;
    assign wild        = (alm[f][DW-1:DW-2] == 2'b11);
    assign field_ok[f] = wild | (alm[f] == now_t[f]);
  end

  assign hit = &field_ok;

endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 3,
  parameter int unsigned NF = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [AW-1:0]         addr,
  input  logic [DW-1:0]         wdata,
  output logic [NF-1:0][DW-1:0] alm,
  output irq_vec_t              en,
  output logic                  inhibit
);
  localparam logic [AW-1:0] CTL_A = AW'(ADDR_CTL);

  logic ctl_we;
  logic inh_rise;

  assign ctl_we   = wr_en && (addr == CTL_A);
  assign inh_rise = wdata[BIT_TOP] & ~inhibit;

  for (genvar f = 0; f < NF; f++) begin : g_alm
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        alm[f] <= '0;
      end else if (wr_en && (addr == AW'(f))) begin
        alm[f] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inhibit <= 1'b0;
      en      <= '0;
    end else if (ctl_we) begin
      inhibit <= wdata[BIT_TOP];
      en.pf   <= wdata[BIT_PF];
      en.af   <= wdata[BIT_AF];
      en.uf   <= wdata[BIT_UF] & ~inh_rise;
    end
  end

  AST_UIE_ON_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inhibit) |-> !en.uf);  // R6

  AST_EN_HOST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctl_we) |-> ($stable(en.pf) && $stable(en.af)));  // R7

endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
  import rtc_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     upd,
  input  logic     alarm_hit,
  input  logic     clr,
  input  irq_vec_t en,
  output irq_vec_t flags,
  output logic     irq_n
);
  irq_vec_t set_v;
  irq_vec_t keep_v;

  always_comb begin
    set_v.pf = tick;
    set_v.af = upd & alarm_hit;
    set_v.uf = upd;
    keep_v   = clr ? irq_vec_t'('0) : flags;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
    end else begin
      flags <= keep_v | set_v;
    end
  end

  assign irq_n = ~|(flags & en);

  AST_PF_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> flags.pf);  // R1

  AST_UF_ON_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> flags.uf);  // R2

  AST_AF_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && alarm_hit) |=> flags.af);  // R3

  AST_AF_ONLY_AFTER_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags.af) |-> $past(upd));  // R10

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !tick && !upd) |=> (flags == '0));  // R9

endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
  import rtc_irq_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          upd_i,
  input  logic [DW-1:0] sec_i,
  input  logic [DW-1:0] min_i,
  input  logic [DW-1:0] hour_i,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq_n
);
  localparam int unsigned   NF     = 3;
  localparam logic [AW-1:0] STAT_A = AW'(ADDR_STAT);
  localparam logic [AW-1:0] CTL_A  = AW'(ADDR_CTL);

  logic [NF-1:0][DW-1:0] now_t;
  logic [NF-1:0][DW-1:0] alm;
  irq_vec_t              en;
  irq_vec_t              flags;
  logic                  inhibit;
  logic                  hit;
  logic                  stat_rd;

  assign now_t   = {hour_i, min_i, sec_i};
  assign stat_rd = rd_en && (addr == STAT_A);

  rtc_irq_ctrl #(.DW(DW), .AW(AW), .NF(NF)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .alm     (alm),
    .en      (en),
    .inhibit (inhibit)
  );

  rtc_alarm_match #(.DW(DW), .NF(NF)) u_match (
    .now_t (now_t),
    .alm   (alm),
    .hit   (hit)
  );

  rtc_irq_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_i),
    .upd       (upd_i),
    .alarm_hit (hit),
    .clr       (stat_rd),
    .en        (en),
    .flags     (flags),
    .irq_n     (irq_n)
  );

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      for (int f = 0; f < NF; f++) begin
        if (addr == AW'(f)) rdata = alm[f];
      end
      if (addr == CTL_A) begin
        rdata[BIT_TOP] = inhibit;
        rdata[BIT_PF]  = en.pf;
        rdata[BIT_AF]  = en.af;
        rdata[BIT_UF]  = en.uf;
      end
      if (addr == STAT_A) begin
        rdata[BIT_TOP] = ~irq_n;
        rdata[BIT_PF]  = flags.pf;
        rdata[BIT_AF]  = flags.af;
        rdata[BIT_UF]  = flags.uf;
      end
    end
  end

  AST_IRQ_WHEN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags.pf && en.pf) || (flags.af && en.af) || (flags.uf && en.uf)) |-> !irq_n);  // R5

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!(flags.pf && en.pf) && !en.af && !(flags.uf && en.uf)) |-> irq_n);  // R5

  AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !tick_i && !upd_i) |=> irq_n);  // R9

endmodule

// File: tb/rtc_irq_unit_bench.sv
module rtc_irq_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0, upd_i = 1'b0;
  logic [7:0] sec_i = '0, min_i = '0, hour_i = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_n;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_irq_unit u_rtc_irq_unit (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .upd_i(upd_i),
    .sec_i(sec_i), .min_i(min_i), .hour_i(hour_i),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_n(irq_n)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse(input logic t, input logic u);
    @(negedge clk); tick_i = t; upd_i = u;
    @(negedge clk); tick_i = 1'b0; upd_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: reset state
    check("R7 irq_n after reset", int'(irq_n), 1);
    rd(3, d); check("R7 control after reset", int'(d), 0);
    rd(4, d); check("R7 status after reset", int'(d), 0);
    rd(2, d); check("R7 hour alarm after reset", int'(d), 0);

    // R5 R1 R2 R8: every enable pattern against every reachable flag pattern
    wr(0, 8'hC0); wr(1, 8'hC0);
    for (int e = 0; e < 8; e++) begin
      for (int p = 0; p < 2; p++) begin
        for (int k = 0; k < 3; k++) begin
          logic [2:0] fl;
          logic       ex;
          hour_i = 8'h00;
          wr(2, (k == 2) ? 8'hC0 : 8'h23);
          wr(3, {1'b0, 3'(e), 4'b0});
          rd(4, d);
          pulse(1'(p), k != 0);
          fl = {1'(p), k == 2, k != 0};
          ex = |(fl & 3'(e));
          check("R5 irq_n vs enabled flags", int'(irq_n), int'(!ex));
          rd(4, d);
          check("R8 R1 R2 status byte", int'(d), int'({ex, fl, 4'b0}));
          rd(3, d);
          check("R7 enables unchanged by events", int'(d), int'({1'b0, 3'(e), 4'b0}));
        end
      end
    end
    wr(3, 8'h00);

    // R3: seconds sweep against fixed alarm
    wr(0, 8'h25); wr(1, 8'h10); wr(2, 8'h07);
    min_i = 8'h10; hour_i = 8'h07;
    for (int s = 0; s < 64; s++) begin
      sec_i = 8'(s);
      rd(4, d);
      pulse(1'b0, 1'b1);
      rd(4, d);
      check("R3 alarm flag per seconds value", int'(d[5]), int'(s == 37));
    end
    // R3: minutes mismatch alone blocks
    sec_i = 8'h25; min_i = 8'h11;
    rd(4, d); pulse(1'b0, 1'b1); rd(4, d);
    check("R3 minutes mismatch", int'(d[5]), 0);

    // R4: wildcard masks
    for (int m = 0; m < 8; m++) begin
      wr(0, m[0] ? 8'hC5 : 8'h22);
      wr(1, m[1] ? 8'hC5 : 8'h22);
      wr(2, m[2] ? 8'hC5 : 8'h22);
      sec_i = 8'h11; min_i = 8'h11; hour_i = 8'h11;
      rd(4, d); pulse(1'b0, 1'b1); rd(4, d);
      check("R4 wildcard mask, times differ", int'(d[5]), int'(m == 7));
      sec_i = 8'h22; min_i = 8'h22; hour_i = 8'h22;
      rd(4, d); pulse(1'b0, 1'b1); rd(4, d);
      check("R4 wildcard mask, times equal", int'(d[5]), 1);
    end
    wr(1, 8'hC0); wr(2, 8'hC0); sec_i = 8'h00;
    wr(0, 8'h80); rd(4, d); pulse(1'b0, 1'b1); rd(4, d);
    check("R4 top bits 10 not wild", int'(d[5]), 0);
    wr(0, 8'h40); rd(4, d); pulse(1'b0, 1'b1); rd(4, d);
    check("R4 top bits 01 not wild", int'(d[5]), 0);

    // R5: alarm flag set, alarm enable 0 -> no interrupt; then enabled
    wr(0, 8'hC0);
    rd(4, d); pulse(1'b0, 1'b1);
    check("R5 alarm flag masked", int'(irq_n), 1);
    wr(3, 8'h20);
    check("R5 alarm flag enabled", int'(irq_n), 0);
    rd(4, d);
    check("R9 read releases irq", int'(irq_n), 1);

    // R10: held match without strobe does not set alarm again
    rd(4, d);
    for (int i = 0; i < 5; i++) pulse(1'b1, 1'b0);
    rd(4, d);
    check("R10 no alarm without strobe", int'(d[5]), 0);
    check("R10 periodic still seen", int'(d[6]), 1);
    wr(3, 8'h00);

    // R9: tick collides with status read
    rd(4, d);
    @(negedge clk); rd_en = 1'b1; addr = 3'd4; tick_i = 1'b1;
    @(negedge clk); rd_en = 1'b0; tick_i = 1'b0;
    rd(4, d);
    check("R9 tick wins over clear", int'(d), 8'h40);
    rd(4, d);
    check("R9 flags cleared by read", int'(d), 0);

    // R6: set-inhibit edge clears update enable
    wr(3, 8'h10);
    rd(3, d); check("R6 update enable stored", int'(d), 8'h10);
    wr(3, 8'h90);
    rd(3, d); check("R6 inhibit rise clears update enable", int'(d), 8'h80);
    wr(3, 8'h90);
    rd(3, d); check("R6 inhibit held keeps update enable", int'(d), 8'h90);
    wr(3, 8'h10);
    rd(3, d); check("R6 inhibit fall keeps update enable", int'(d), 8'h10);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule